// File: doc/BRIEF.md
# Receive Descriptor Writer

This block moves received frames from a byte stream into memory buffers described by a chain of receive descriptors. Each descriptor is four 32-bit words: status and length, buffer start address, a reserved word and the address of the next descriptor. When a frame starts and reception is on, the block reads the current descriptor. If the descriptor belongs to the MAC it reads the buffer and next-descriptor addresses, packs the frame bytes into 32-bit words with byte strobes and writes them into the buffer. It then writes the status and length word back, which also gives the descriptor back to the CPU, and moves on to the next descriptor.

Frames longer than the configured maximum are either discarded or, when long frames are allowed, kept and marked as too long. A frame that finds a CPU-owned descriptor is thrown away and reported as descriptor-unavailable. Three single-cycle event pulses report good reception, the first buffer write of a frame and a missing descriptor. No poll request is needed: a frame arriving on the stream starts the descriptor fetch by itself.

Top module: `rxd_writer`

## Requirements
- R1: After reset the block is idle: `in_ready` and `mem_req` are low, `cur_desc` is 0 and no event pulses.
- R2: A rising edge of `ctl_rx_on` while idle loads `cur_desc` from `desc_base`. While `ctl_rx_on` is low and the block is idle, no byte is accepted and no memory access is made.
- R3: For each frame the block reads the status word at `cur_desc`, the buffer address at `cur_desc`+4 and the next address at `cur_desc`+12. It never writes the reserved word at +8, and it ignores the two low bits of the buffer address.
- R4: Frame byte k is stored at buffer+k, little-endian within each word (byte k in lane k mod 4). Each word write has strobes only for the frame's bytes, so memory bytes past the frame stay untouched.
- R5: The status writeback is one full-word write to `cur_desc` with bits 31:30 = 00 (CPU owner), bit 20 = 1 (good), bit 19 = too long, bit 16 = `ctl_irq_en`, bits 15:0 = byte count + 4 and all other bits 0.
- R6: After a writeback `cur_desc` equals the next-descriptor address read for that frame, and `evt_rx_good` pulses exactly once.
- R7: `evt_early` pulses exactly once per stored frame, in the cycle its first buffer word write is acknowledged.
- R8: A frame is too long when byte count + 4 > `MAX_LEN`. With `ctl_long_ok` = 1 it is stored in full with bit 19 set. With `ctl_long_ok` = 0 its remaining bytes are consumed and discarded: no writeback, `cur_desc` unchanged, no `evt_rx_good`.
- R9: A descriptor whose bits 31:30 are not 10 causes the whole frame to be consumed and discarded, with one `evt_desc_unavail` pulse, no memory write and `cur_desc` unchanged.
- R10: A memory request keeps its address and direction stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_rx_on | input | 1 | Reception enable |
| ctl_long_ok | input | 1 | Keep frames above the length limit |
| ctl_irq_en | input | 1 | Value written to status bit 16 |
| desc_base | input | ADDR_W | First descriptor, loaded when reception is turned on |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Block takes the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_strb | output | 4 | Byte lane enables for writes |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| cur_desc | output | ADDR_W | Current descriptor address |
| evt_rx_good | output | 1 | Frame written back |
| evt_early | output | 1 | First buffer word of a frame written |
| evt_desc_unavail | output | 1 | Frame found a CPU-owned descriptor |

## Verification
Frame lengths from 1 to 9 bytes cover every end position within a word, so they show whether the strobes and lane packing are right and whether bytes past the frame are left alone. Lengths just under, at and over the limit, tried with long frames both allowed and refused, show the exact threshold and tell the keep path from the discard path. A CPU-owned descriptor, a buffer address with low bits set and a reload of the descriptor base after reception is turned off and on again check the ownership test, the address alignment and the start pointer.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LEN_FIELD_W = 16;
  localparam int CRC_BYTES = 4;
  localparam logic [1:0] OWN_MAC = 2'b10;
  localparam logic [1:0] OWN_CPU = 2'b00;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_STAT, S_RD_BUF, S_RD_NEXT,
    S_RECV, S_WR_DATA, S_WR_STAT, S_DROP
  } rxd_state_e;

  function automatic logic owned_by_mac(input logic [31:0] w);
    return w[31:30] == OWN_MAC;
  endfunction

  function automatic logic too_long(input logic [LEN_FIELD_W-1:0] nbytes,
                                    input logic [LEN_FIELD_W-1:0] maxlen);
    return ({1'b0, nbytes} + (LEN_FIELD_W+1)'(CRC_BYTES)) > {1'b0, maxlen};
  endfunction

  function automatic logic [31:0] status_word(input logic [LEN_FIELD_W-1:0] nbytes,
                                              input logic big, input logic irq);
    logic [31:0] w;
    w = '0;
    w[31:30] = OWN_CPU;
    w[20] = 1'b1;
    w[19] = big;
    w[16] = irq;
    w[15:0] = nbytes + LEN_FIELD_W'(CRC_BYTES);
    return w;
  endfunction
endpackage

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [7:0]         din,
  output logic [8*BYTES-1:0] word,
  output logic [BYTES-1:0]   strb,
  output logic               lane_last
);
  localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  logic [LANE_W-1:0] lane;

  assign lane_last = (lane == LANE_W'(BYTES-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane <= '0;
    else if (clr) lane <= '0;
    else if (push) lane <= lane_last ? '0 : lane + 1'b1;
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word[8*g +: 8] <= '0;
        strb[g] <= 1'b0;
      end else if (clr) begin
        strb[g] <= 1'b0;
      end else if (push && lane == LANE_W'(g)) begin
        word[8*g +: 8] <= din;
        strb[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxd_len_track.sv
module rxd_len_track
  import rxd_pkg::*;
#(
  parameter int MAX_LEN = 1518
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   inc,
  output logic [LEN_FIELD_W-1:0] count,
  output logic                   next_too_long
);
  logic [LEN_FIELD_W-1:0] count_next;

  assign count_next = count + 1'b1;
  assign next_too_long = too_long(count_next, LEN_FIELD_W'(MAX_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count_next;
  end
endmodule

// File: rtl/rxd_writer.sv
module rxd_writer
  import rxd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_rx_on,
  input  logic              ctl_long_ok,
  input  logic              ctl_irq_en,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_strb,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [ADDR_W-1:0] cur_desc,
  output logic              evt_rx_good,
  output logic              evt_early,
  output logic              evt_desc_unavail
);
  localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_NEXT = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);

  rxd_state_e st;
  logic [ADDR_W-1:0] wr_addr, nxt_desc;
  logic last_seen, big, first_wr, rx_on_q;

  // named internal events
  logic hs, drop_now, keep_byte, pk_clr, len_clr;
  logic [31:0] pk_word;
  logic [3:0]  pk_strb;
  logic        pk_lane_last;
  logic [LEN_FIELD_W-1:0] len_count;
  logic len_next_tl;
  logic st_idle, start_frame, rx_on_rise;

  assign st_idle     = (st == S_IDLE);
  assign rx_on_rise  = ctl_rx_on && !rx_on_q;
  assign start_frame = st_idle && ctl_rx_on && rx_on_q && in_valid;
  assign in_ready    = (st == S_RECV) || (st == S_DROP);
  assign hs          = in_valid && in_ready;
  assign drop_now    = len_next_tl && !ctl_long_ok;
  assign keep_byte   = (st == S_RECV) && hs && !drop_now;
  assign pk_clr      = ((st == S_WR_DATA) && mem_ack) || ((st == S_RD_NEXT) && mem_ack);
  assign len_clr     = (st == S_RD_NEXT) && mem_ack;

  rxd_byte_packer #(.BYTES(WORD_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .push(keep_byte), .din(in_data),
    .word(pk_word), .strb(pk_strb), .lane_last(pk_lane_last)
  );

  rxd_len_track #(.MAX_LEN(MAX_LEN)) u_len (
    .clk(clk), .rst_n(rst_n), .clr(len_clr), .inc(keep_byte),
    .count(len_count), .next_too_long(len_next_tl)
  );

  assign evt_desc_unavail = (st == S_RD_STAT) && mem_ack && !owned_by_mac(mem_rdata);
  assign evt_early        = (st == S_WR_DATA) && mem_ack && first_wr;
  assign evt_rx_good      = (st == S_WR_STAT) && mem_ack;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_desc;
    mem_wdata = '0;
    mem_strb  = '0;
    unique case (st)
      S_RD_STAT: mem_req = 1'b1;
      S_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_desc + OFS_BUF; end
      S_RD_NEXT: begin mem_req = 1'b1; mem_addr = cur_desc + OFS_NEXT; end
      S_WR_DATA: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = wr_addr;
        mem_wdata = pk_word; mem_strb = pk_strb;
      end
      S_WR_STAT: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_wdata = status_word(len_count, big, ctl_irq_en);
        mem_strb = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_desc  <= '0;
      wr_addr   <= '0;
      nxt_desc  <= '0;
      last_seen <= 1'b0;
      big       <= 1'b0;
      first_wr  <= 1'b0;
      rx_on_q   <= 1'b0;
    end else begin
      rx_on_q <= ctl_rx_on;
      unique case (st)
        S_IDLE: begin
          if (rx_on_rise) cur_desc <= desc_base;
          else if (start_frame) st <= S_RD_STAT;
        end
        S_RD_STAT: if (mem_ack) st <= owned_by_mac(mem_rdata) ? S_RD_BUF : S_DROP;
        S_RD_BUF: if (mem_ack) begin
          wr_addr <= {mem_rdata[ADDR_W-1:2], 2'b00};
          st <= S_RD_NEXT;
        end
        S_RD_NEXT: if (mem_ack) begin
          nxt_desc  <= mem_rdata[ADDR_W-1:0];
          big       <= 1'b0;
          last_seen <= 1'b0;
          first_wr  <= 1'b1;
          st        <= S_RECV;
        end
        S_RECV: if (hs) begin
          if (drop_now) st <= in_last ? S_IDLE : S_DROP;
          else begin
            big       <= big | len_next_tl;
            last_seen <= in_last;
            if (pk_lane_last || in_last) st <= S_WR_DATA;
          end
        end
        S_WR_DATA: if (mem_ack) begin
          wr_addr  <= wr_addr + STEP;
          first_wr <= 1'b0;
          st       <= last_seen ? S_WR_STAT : S_RECV;
        end
        S_WR_STAT: if (mem_ack) begin
          cur_desc <= nxt_desc;
          st       <= S_IDLE;
        end
        S_DROP: if (hs && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_writer_chk.sv
module rxd_writer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_rx_on,
  input logic              st_idle,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_strb,
  input logic [31:0]       mem_rdata,
  input logic              evt_rx_good,
  input logic              evt_early,
  input logic              evt_desc_unavail
);
  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_off_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && !ctl_rx_on |=> st_idle);

  assert_write_has_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_strb != 4'h0);

  assert_good_returns_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_good |-> mem_req && mem_we && mem_ack && mem_strb == 4'hF &&
                    mem_wdata[31:30] == 2'b00 && mem_wdata[20] && mem_wdata[15:0] >= 16'd5);

  assert_early_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_early |-> mem_req && mem_we && mem_ack && mem_strb[0]);

  assert_unavail_on_cpu_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_desc_unavail |-> mem_req && !mem_we && mem_ack && mem_rdata[31:30] != 2'b10);

  assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_rx_good, evt_early, evt_desc_unavail}));
endmodule

bind rxd_writer rxd_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_rx_on(ctl_rx_on), .st_idle(st_idle),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_strb(mem_strb), .mem_rdata(mem_rdata),
  .evt_rx_good(evt_rx_good), .evt_early(evt_early), .evt_desc_unavail(evt_desc_unavail)
);

// File: tb/sim_rxd_writer.sv
`timescale 1ns/1ps
module sim_rxd_writer;
  localparam int LIM = 64;

  logic clk = 0, rst_n = 0;
  logic ctl_rx_on = 0, ctl_long_ok = 0, ctl_irq_en = 0;
  logic [31:0] desc_base = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_desc;
  logic [3:0] mem_strb;
  logic evt_rx_good, evt_early, evt_desc_unavail;

  logic [31:0] mem [0:1023];
  logic ack_q = 0;
  int n_chk = 0, n_fail = 0;
  int c_good = 0, c_early = 0, c_rdu = 0, c_req = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rxd_writer #(.ADDR_W(32), .MAX_LEN(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_rx_on(ctl_rx_on), .ctl_long_ok(ctl_long_ok),
    .ctl_irq_en(ctl_irq_en), .desc_base(desc_base), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_strb(mem_strb),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cur_desc(cur_desc),
    .evt_rx_good(evt_rx_good), .evt_early(evt_early), .evt_desc_unavail(evt_desc_unavail)
  );

  assign mem_ack = ack_q;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    ack_q <= mem_req && !ack_q;
    if (mem_req && mem_we && mem_ack)
      for (int b = 0; b < 4; b++)
        if (mem_strb[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  always @(negedge clk) begin
    if (evt_rx_good) c_good++;
    if (evt_early) c_early++;
    if (evt_desc_unavail) c_rdu++;
    if (mem_req) c_req++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s * 7 + k * 13 + 1) & 255);
  endfunction

  function automatic logic [7:0] rd_byte(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  function automatic int buf_of(input int d);
    return 32'h400 + 32'h80 * d;
  endfunction

  task automatic send(input int len, input int s);
    for (int k = 0; k < len; k++) begin
      in_valid = 1; in_data = pat(s, k); in_last = (k == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    repeat (12) @(negedge clk);
  endtask

  // mode 0 stored, 1 discarded as too long, 2 CPU-owned descriptor
  task automatic frame(input int len, input bit irq, input bit lok, input int mode);
    int d, s, g0, e0, r0, bad;
    logic [31:0] stat0, expw;
    d = int'(cur_desc >> 4);
    s = len + d;
    stat0 = (mode == 2) ? 32'h0000_1234 : 32'h8000_0000;
    mem[d*4] = stat0;
    for (int w = 0; w < 32; w++) mem[(buf_of(d) >> 2) + w] = 32'hEEEE_EEEE;
    ctl_irq_en = irq; ctl_long_ok = lok;
    g0 = c_good; e0 = c_early; r0 = c_rdu;
    send(len, s);
    check("R3 reserved word", mem[d*4+2], 32'hDEAD_0000 + d);
    if (mode == 0) begin
      expw = 32'h0010_0000 | 32'(len + 4);
      if (irq) expw |= 32'h0001_0000;
      if (len + 4 > LIM) expw |= 32'h0008_0000;
      check((len + 4 > LIM) ? "R8 long kept status" : "R5 status", mem[d*4], expw);
      bad = 0;
      for (int k = 0; k < len; k++) if (rd_byte(buf_of(d) + k) !== pat(s, k)) bad++;
      check("R4 data bytes", bad, 0);
      check("R4 byte past end", rd_byte(buf_of(d) + len), 8'hEE);
      check("R6 next desc", cur_desc, 32'(16 * ((d + 1) % 4)));
      check("R6 good event", c_good - g0, 1);
      check("R7 early event", c_early - e0, 1);
    end else if (mode == 1) begin
      check("R8 no writeback", mem[d*4], stat0);
      check("R8 desc kept", cur_desc, 32'(16 * d));
      check("R8 no good event", c_good - g0, 0);
    end else begin
      check("R9 unavail event", c_rdu - r0, 1);
      check("R9 status untouched", mem[d*4], stat0);
      check("R9 desc kept", cur_desc, 32'(16 * d));
      check("R9 buffer untouched", rd_byte(buf_of(d)), 8'hEE);
      check("R9 no good event", c_good - g0, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int r0;
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    for (int d = 0; d < 4; d++) begin
      mem[d*4+1] = buf_of(d) + ((d % 2 == 1) ? 1 : 0);  // R3 low bits ignored
      mem[d*4+2] = 32'hDEAD_0000 + d;
      mem[d*4+3] = 16 * ((d + 1) % 4);
    end
    repeat (3) @(negedge clk);
    check("R1 in_ready", in_ready, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 cur_desc", cur_desc, 0);
    check("R1 events", {evt_rx_good, evt_early, evt_desc_unavail}, 0);
    rst_n = 1;
    desc_base = 32'h10;
    @(negedge clk); ctl_rx_on = 1;
    repeat (3) @(negedge clk);
    check("R2 base load", cur_desc, 32'h10);

    for (int len = 1; len <= 9; len++) frame(len, len % 2, 0, 0);
    frame(LIM - 5, 1, 0, 0);
    frame(LIM - 4, 0, 0, 0);
    frame(LIM - 3, 1, 0, 1);
    frame(LIM - 3, 1, 1, 0);
    frame(100, 0, 1, 0);
    frame(100, 1, 0, 1);
    frame(7, 1, 0, 2);
    frame(5, 0, 0, 0);

    // reception off: nothing taken, then reload base
    @(negedge clk); ctl_rx_on = 0;
    @(negedge clk);
    r0 = c_req;
    in_valid = 1; in_data = 8'h55; in_last = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (in_ready) seen++; end
      check("R2 no byte taken while off", seen, 0);
    end
    check("R2 no memory access while off", c_req - r0, 0);
    in_valid = 0; in_last = 0;
    desc_base = 32'h20;
    @(negedge clk); ctl_rx_on = 1;
    repeat (3) @(negedge clk);
    check("R2 base reload", cur_desc, 32'h20);
    frame(3, 1, 0, 0);
    check("R6 chain advance", cur_desc, 32'h30);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule